// File: doc/BRIEF.md
# Partial Word Byte-Store Unit

This unit converts a request to store the leading or trailing part of a word into a single write to a 32-bit, word-aligned, big-endian memory port. Each request carries an operation select, a byte address and a 32-bit register value. The two low address bits give the offset inside the word.

In the begin form, the unit writes from the addressed byte to the last byte of the word, taking the low-order bytes of the value. In the end form, it writes the bytes that come before the addressed byte, taking the high-order bytes of the value. Each request produces exactly one transaction, so a three-byte update is one beat and is never split.

The end form at offset zero stores no bytes. The unit still has to check write permission for that address, so in that case it issues a one-cycle probe strobe and sends nothing to the memory port.

Top module: `byte_store_unit`

## Requirements
- R1: In begin mode (mode_end_i=0) with offset k = addr_i[1:0], mem_be_o enables byte addresses k..3. Bit 3 of the mask selects byte 0 (data bits 31:24) and bit 0 selects byte 3 (bits 7:0). This gives 1111, 0111, 0011 and 0001 for k = 0..3.
- R2: In end mode (mode_end_i=1), mem_be_o enables byte addresses 0..k-1. This gives 1000, 1100 and 1110 for k = 1..3.
- R3: mem_wdata_o carries value_i unshifted in every enabled lane and zero in every disabled lane. In begin mode the low-order bytes land at the addressed end of the word; in end mode the high-order bytes land at its start.
- R4: mem_addr_o equals the request address with bits 1:0 cleared.
- R5: The cycle after a request is accepted, mem_req_o rises. Address, mask and data then stay stable, and mem_req_o stays high, until mem_ack_i is sampled high. Every request, including a three-byte one, gives exactly one beat.
- R6: done_o is high for exactly one cycle, the cycle after the acknowledge (or after the probe). In that cycle mem_req_o is low, and busy_o falls after it.
- R7: End mode at offset 0 raises no mem_req_o. Instead probe_o is high for one cycle, the cycle after acceptance, with probe_addr_o equal to the full byte address.
- R8: start_i while busy_o is high is ignored. The pending transaction and its outputs are unchanged, and no extra transaction follows.
- R9: After reset, mem_req_o, probe_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when busy_o is low |
| mode_end_i | input | 1 | 0: begin form, 1: end form |
| addr_i | input | AW | Byte address |
| value_i | input | 32 | Register value to store |
| busy_o | output | 1 | Request in flight |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Word-aligned write address |
| mem_be_o | output | 4 | Byte enables, bit 3 = byte 0 |
| mem_wdata_o | output | 32 | Write data, disabled lanes zero |
| mem_ack_i | input | 1 | Memory acknowledge |
| probe_o | output | 1 | One-cycle write-permission probe strobe |
| probe_addr_o | output | AW | Byte address to probe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs all eight combinations of mode and offset. Each uses a value whose four bytes are all different, so a lane that is misplaced, unmasked or shifted shows up in the data. The word address uses nonzero upper bits, so clearing the wrong address bits is also caught.

The acknowledge delay is varied from zero to several cycles, which separates holding the request stable from dropping it early or repeating it. The end-form offset-zero case separates a probe from a zero-mask write. A start issued mid-transaction shows whether the unit wrongly accepts a second request.

// File: rtl/byte_store_pkg.sv
package byte_store_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic {
    OP_BEGIN = 1'b0,
    OP_END   = 1'b1
  } bs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_PROBE,
    ST_DONE
  } bs_state_e;
endpackage

// File: rtl/bs_lane_decode.sv
module bs_lane_decode
  import byte_store_pkg::*;
(
  input  bs_op_e              op_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   value_i,
  output logic [LANES-1:0]    be_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                probe_only_o
);
  // be bit i serves byte address LANES-1-i (big-endian)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned BYTE_IDX = LANES - 1 - i;
    logic at_or_after;
    assign at_or_after = (BYTE_IDX >= int'(off_i));
    assign be_o[i] = (op_i == OP_BEGIN) ? at_or_after : !at_or_after;
    assign wdata_o[8*i +: 8] = be_o[i] ? value_i[8*i +: 8] : 8'h00;
  end

  assign probe_only_o = (be_o == '0);
endmodule

// File: rtl/bs_port_ctrl.sv
module bs_port_ctrl
  import byte_store_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              probe_only_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              probe_o,
  output logic [AW-1:0]     probe_addr_o,
  output logic              done_o
);
  bs_state_e         state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = probe_only_i ? ST_PROBE : ST_WRITE;
      ST_WRITE: if (mem_ack_i) state_d = ST_DONE;
      ST_PROBE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_i;
        be_q   <= be_i;
        data_q <= wdata_i;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_req_o    = (state_q == ST_WRITE);
  assign probe_o      = (state_q == ST_PROBE);
  assign done_o       = (state_q == ST_DONE);
  assign mem_addr_o   = {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_be_o     = be_q;
  assign mem_wdata_o  = data_q;
  assign probe_addr_o = addr_q;
endmodule

// File: rtl/byte_store_unit.sv
module byte_store_unit
  import byte_store_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_end_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       value_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  output logic              probe_o,
  output logic [AW-1:0]     probe_addr_o,
  output logic              done_o
);
  logic [LANES-1:0]  dec_be;
  logic [DATA_W-1:0] dec_data;
  logic              dec_probe_only;
  bs_op_e            op;

  assign op = bs_op_e'(mode_end_i);

  bs_lane_decode u_decode (
    .op_i         (op),
    .off_i        (addr_i[OFF_W-1:0]),
    .value_i      (value_i),
    .be_o         (dec_be),
    .wdata_o      (dec_data),
    .probe_only_o (dec_probe_only)
  );

  bs_port_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .be_i         (dec_be),
    .wdata_i      (dec_data),
    .probe_only_i (dec_probe_only),
    .mem_ack_i    (mem_ack_i),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .probe_o      (probe_o),
    .probe_addr_o (probe_addr_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    mem_be_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          probe_o,
  input logic          done_o
);
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_be_o) && $stable(mem_wdata_o));

  assert_start_reacts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> mem_req_o || probe_o);

  assert_ack_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> done_o && !mem_req_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_probe_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_o |=> !probe_o && done_o);

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, probe_o, done_o}));

  assert_req_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_be_o != 4'b0000);

  assert_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  for (genvar i = 0; i < 4; i++) begin : g_lane_chk
    assert_lane_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_be_o[i] |-> mem_wdata_o[8*i +: 8] == 8'h00);
  end
endmodule

bind byte_store_unit bs_checker #(.AW(AW)) u_bs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .probe_o     (probe_o),
  .done_o      (done_o)
);

// File: tb/byte_store_unit_tb_top.sv
`timescale 1ns/1ps
module byte_store_unit_tb_top;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_end_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   value_i = '0;
  logic          mem_ack_i = 1'b0;
  logic          busy_o, mem_req_o, probe_o, done_o;
  logic [AW-1:0] mem_addr_o, probe_addr_o;
  logic [3:0]    mem_be_o;
  logic [31:0]   mem_wdata_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  byte_store_unit #(.AW(AW)) dut_i (
    .clk_i, .rst_ni, .start_i, .mode_end_i, .addr_i, .value_i,
    .busy_o, .mem_req_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_ack_i, .probe_o, .probe_addr_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input bit end_mode, input int off);
    logic [3:0] m;
    for (int b = 0; b < 4; b++) begin
      bit en;
      en = end_mode ? (b < off) : (b >= off);
      m[3-b] = en;
    end
    return m;
  endfunction

  function automatic logic [31:0] exp_data(input logic [3:0] be, input logic [31:0] v);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) d[8*i +: 8] = be[i] ? v[8*i +: 8] : 8'h00;
    return d;
  endfunction

  // one request; ack_delay = negedges with ack low before ack
  task automatic run_req(input bit end_mode, input logic [AW-1:0] addr,
                         input logic [31:0] val, input int ack_delay,
                         input bit poke_busy);
    logic [3:0]  be;
    logic [31:0] d;
    int off;
    off = int'(addr[1:0]);
    be  = exp_be(end_mode, off);
    d   = exp_data(be, val);
    start_i = 1'b1; mode_end_i = end_mode; addr_i = addr; value_i = val;
    @(negedge clk_i);
    start_i = 1'b0;
    if (be == 4'b0000) begin
      chk(probe_o == 1'b1 && mem_req_o == 1'b0, "R7 probe strobe", {probe_o, mem_req_o}, 2'b10);
      chk(probe_addr_o == addr, "R7 probe address", probe_addr_o, addr);
      @(negedge clk_i);
      chk(probe_o == 1'b0 && done_o == 1'b1, "R6 done after probe", {probe_o, done_o}, 2'b01);
    end else begin
      chk(mem_req_o == 1'b1, "R5 request raised", mem_req_o, 1);
      chk(mem_be_o == be, end_mode ? "R2 end mask" : "R1 begin mask", mem_be_o, be);
      chk(mem_wdata_o == d, "R3 lane data", mem_wdata_o, d);
      chk(mem_addr_o == {addr[AW-1:2], 2'b00}, "R4 word address", mem_addr_o,
          {addr[AW-1:2], 2'b00});
      for (int w = 0; w < ack_delay; w++) begin
        if (poke_busy && w == 0) begin
          start_i = 1'b1; mode_end_i = ~end_mode; addr_i = addr ^ 32'h5; value_i = ~val;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        chk(mem_req_o && mem_be_o == be && mem_wdata_o == d && !done_o,
            poke_busy ? "R8 busy start ignored" : "R5 held until ack",
            {mem_req_o, mem_be_o, mem_wdata_o}, {1'b1, be, d});
      end
      mem_ack_i = 1'b1;
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      chk(done_o == 1'b1 && mem_req_o == 1'b0, "R6 done after ack", {done_o, mem_req_o}, 2'b10);
    end
    @(negedge clk_i);
    chk(!done_o && !busy_o && !mem_req_o && !probe_o, "R6 return idle",
        {done_o, busy_o, mem_req_o, probe_o}, 4'b0000);
    if (poke_busy) begin
      @(negedge clk_i);
      chk(!mem_req_o && !probe_o, "R8 no extra transaction", {mem_req_o, probe_o}, 2'b00);
    end
  endtask

  task automatic t_reset;
    chk(!mem_req_o && !probe_o && !done_o && !busy_o, "R9 reset state",
        {mem_req_o, probe_o, done_o, busy_o}, 4'b0000);
  endtask

  task automatic t_begin_all;
    for (int k = 0; k < 4; k++)
      run_req(1'b0, 32'h1234_5670 | k, 32'hA1B2_C3D4, k, 1'b0);
  endtask

  task automatic t_end_all;
    for (int k = 3; k >= 0; k--)
      run_req(1'b1, 32'h8765_4320 | k, 32'h1F2E_3D4C, 3 - k, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_req(1'b0, 32'h0000_0F01, 32'hCAFE_F00D, 3, 1'b1);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_begin_all();
    t_end_all();
    t_busy_ignore();
    run_req(1'b1, 32'hFFFF_FFF3, 32'h0102_0304, 0, 1'b0);
    run_req(1'b1, 32'h0000_0004, 32'hDEAD_BEEF, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule